// File: doc/BRIEF.md
# Multi-Format SPI Master Word Engine

This block is the shift engine of a master-mode SPI port. It serves one target behind a single active-low chip select. Four word profiles are held in the block and written through a small configuration port. A profile sets the data length (2 to 16 bits), the idle clock level, the clock phase and the bit-rate divider. It also sets whether the first bit on the wire is the most or least significant one, whether a parity bit follows the data and which parity sense it uses, and how many serial clock periods the chip select must stay high after the word.

A word is offered as a 16-bit right-aligned value together with a 2-bit profile selector, through a valid/ready handshake. The engine latches the chosen profile at acceptance, so the profile can be rewritten while a word is being shifted. The word received in the same frame is returned right-aligned with its upper bits cleared, together with a one-cycle valid strobe. A parity mismatch sets a sticky error flag and, when enabled, gives a one-cycle interrupt pulse.

Top module: `spi_fmt_master`

## Requirements
- R1: A configuration write (`cfg_we`) stores all fields into profile `cfg_idx`. Each accepted word uses the profile named by `tx_fmt`, latched at acceptance. Later writes do not change a word already in flight.
- R2: SCLK idles at the profile's `cpol` level. Each SCLK half-period lasts `presc+1` clock cycles. Chip select falls `presc+1` cycles before the first SCLK edge and rises `presc+1` cycles after the last one.
- R3: With `cpha=0`, MISO is sampled on leading edges and MOSI changes on trailing edges, with the first bit already on MOSI when chip select falls. With `cpha=1`, MOSI changes on leading edges and MISO is sampled on trailing edges.
- R4: A frame has exactly `len` data bits plus one bit when parity is on, which gives 2×that many SCLK edges. A written length below 2 is stored as 2, and one above 16 is stored as 16.
- R5: With `lsb_first=0`, data leaves starting at bit `len-1` of `tx_data` and goes down to bit 0. With `lsb_first=1`, it leaves starting at bit 0 and goes up. Bits of `tx_data` at or above `len` have no effect on MOSI.
- R6: The received word appears on `rx_data` right-aligned, in the same bit order as the transmit side, with every bit at or above `len` equal to 0.
- R7: With parity on, the bit after the last data bit equals the XOR of the data bits XOR `par_odd`. So `par_odd=0` gives even parity and `par_odd=1` gives odd parity over data plus parity bit.
- R8: When the sampled parity bit differs from the value R7 gives over the received data, `par_err` goes to 1 and stays there until a cycle with `par_err_clr=1`. A new error in the same cycle as a clear wins. `irq` pulses for one cycle on such an error only when `irq_en=1`.
- R9: `tx_ready` is 1 only while no frame or gap is in progress. When the next word is already waiting, the time from chip select rising to chip select falling again is `2*gap*(presc+1)+1` cycles, using the finished word's profile.
- R10: `rx_valid` is a one-cycle pulse in the same cycle that chip select rises, and `rx_data` holds the frame's received word from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Profile write strobe |
| cfg_idx | input | 2 | Profile slot written |
| cfg_len | input | 5 | Data length in bits |
| cfg_cpol | input | 1 | Idle SCLK level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_presc | input | 8 | Half-period divider minus one |
| cfg_gap | input | 8 | Post-word gap in SCLK periods |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can accept a word |
| tx_fmt | input | 2 | Profile selector for the offered word |
| tx_data | input | 16 | Right-aligned transmit word |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 16 | Right-aligned received word |
| par_err | output | 1 | Sticky parity error flag |
| par_err_clr | input | 1 | Clears the parity error flag |
| irq_en | input | 1 | Enables the error interrupt |
| irq | output | 1 | Parity error interrupt pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach from the ports is a pair of back-to-back words whose profiles differ in phase, bit order, divider and gap. In that case the gap timing of the first word must hold while the second word's settings take over. The stimulus keeps the next word waiting on `tx_valid` before chip select rises and picks a random profile for every word. It also rewrites the profile table between bursts. A bench-side target model drives MISO bit by bit and sometimes corrupts the parity bit. Directed frames add the length limits, the 12-bit and 10-bit worked examples, and a parity error that arrives while the clear input is held.

// File: rtl/spi_fmt_pkg.sv
package spi_fmt_pkg;
  localparam int FMT_CNT = 4;
  localparam int WORD_W  = 16;
  localparam int LEN_W   = 5;
  localparam int PRE_W   = 8;
  localparam int GAP_W   = 8;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             cpol;
    logic             cpha;
    logic             lsb_first;
    logic             par_en;
    logic             par_odd;
    logic [PRE_W-1:0] presc;
    logic [GAP_W-1:0] gap;
  } fmt_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL, ST_GAP} eng_st_e;
endpackage

// File: rtl/spi_fmt_store.sv
module spi_fmt_store import spi_fmt_pkg::*; #(
  parameter int NFMT   = FMT_CNT,
  parameter int DATA_W = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(NFMT)-1:0] wr_idx,
  input  fmt_t                    wr_fmt,
  input  logic [$clog2(NFMT)-1:0] rd_idx,
  output fmt_t                    rd_fmt
);
  localparam fmt_t RST_FMT = '{len: LEN_W'(DATA_W), cpol: 1'b0, cpha: 1'b0,
                               lsb_first: 1'b0, par_en: 1'b0, par_odd: 1'b0,
                               presc: '0, gap: '0};

  fmt_t wr_clamped;
  fmt_t slot_q [NFMT];

  always_comb begin
    wr_clamped = wr_fmt;
    if (int'(wr_fmt.len) < 2)           wr_clamped.len = LEN_W'(2);
    else if (int'(wr_fmt.len) > DATA_W) wr_clamped.len = LEN_W'(DATA_W);
  end

  for (genvar g = 0; g < NFMT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q[g] <= RST_FMT;
      else if (wr_en && (int'(wr_idx) == g))       slot_q[g] <= wr_clamped;
    end
  end

  assign rd_fmt = slot_q[rd_idx];
endmodule

// File: rtl/spi_fmt_tick.sv
module spi_fmt_tick #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == presc);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_fmt_order.sv
module spi_fmt_order #(
  parameter int LEN_W = 5,
  parameter int J_W   = 5,
  parameter int IDX_W = 4
) (
  input  logic [LEN_W-1:0] len,
  input  logic             lsb_first,
  input  logic [J_W-1:0]   j,
  output logic [IDX_W-1:0] idx,
  output logic             is_par
);
  logic [LEN_W-1:0] rev;

  assign is_par = int'(j) >= int'(len);
  assign rev    = len - LEN_W'(1) - LEN_W'(j);
  assign idx    = lsb_first ? IDX_W'(j) : IDX_W'(rev);
endmodule

// File: rtl/spi_fmt_master.sv
module spi_fmt_master import spi_fmt_pkg::*; #(
  parameter int NFMT   = FMT_CNT,
  parameter int DATA_W = WORD_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NFMT)-1:0] cfg_idx,
  input  logic [LEN_W-1:0]        cfg_len,
  input  logic                    cfg_cpol,
  input  logic                    cfg_cpha,
  input  logic                    cfg_lsb_first,
  input  logic                    cfg_par_en,
  input  logic                    cfg_par_odd,
  input  logic [PRE_W-1:0]        cfg_presc,
  input  logic [GAP_W-1:0]        cfg_gap,
  input  logic                    tx_valid,
  output logic                    tx_ready,
  input  logic [$clog2(NFMT)-1:0] tx_fmt,
  input  logic [DATA_W-1:0]       tx_data,
  output logic                    rx_valid,
  output logic [DATA_W-1:0]       rx_data,
  output logic                    par_err,
  input  logic                    par_err_clr,
  input  logic                    irq_en,
  output logic                    irq,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso,
  output logic                    cs_n
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int EDGE_W = $clog2(2 * (DATA_W + 1) + 1);
  localparam int J_W    = EDGE_W - 1;
  localparam int GCNT_W = GAP_W + 1;

  fmt_t                cfg_in, sel_fmt, fq_q, fq_d;
  eng_st_e             st_q, st_d;
  logic [EDGE_W-1:0]   edge_q, edge_d;
  logic [GCNT_W-1:0]   gcnt_q, gcnt_d;
  logic [DATA_W-1:0]   txw_q, txw_d, rxw_q, rxw_d, rxd_q, rxd_d, tx_mask;
  logic                rxp_q, rxp_d, mosi_q, mosi_d, sclk_q, sclk_d;
  logic                csn_q, csn_d, rxv_q, rxv_d, perr_q, perr_d, irq_q, irq_d;
  logic                tick, samp_edge, last_edge, drv_valid, drv_bit, first_bit;
  logic                tx_par, perr_now, rx_is_par, tx_is_par;
  logic [EDGE_W-1:0]   nbits, drv_full;
  logic [IDX_W-1:0]    rx_idx, tx_idx;
  logic [LEN_W-1:0]    sel_top;
  logic [GCNT_W-1:0]   gap_last;

  assign cfg_in = '{len: cfg_len, cpol: cfg_cpol, cpha: cfg_cpha,
                    lsb_first: cfg_lsb_first, par_en: cfg_par_en,
                    par_odd: cfg_par_odd, presc: cfg_presc, gap: cfg_gap};

  spi_fmt_store #(.NFMT(NFMT), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_idx(cfg_idx),
    .wr_fmt(cfg_in), .rd_idx(tx_fmt), .rd_fmt(sel_fmt)
  );

  spi_fmt_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(st_q != ST_IDLE),
    .presc(fq_q.presc), .tick(tick)
  );

  // frame geometry
  assign nbits     = EDGE_W'(fq_q.len) + EDGE_W'(fq_q.par_en);
  assign last_edge = (edge_q == EDGE_W'((nbits << 1) - EDGE_W'(1)));
  assign samp_edge = fq_q.cpha ? edge_q[0] : ~edge_q[0];
  assign drv_full  = (edge_q + EDGE_W'(1)) >> 1;
  assign drv_valid = drv_full < nbits;

  spi_fmt_order #(.LEN_W(LEN_W), .J_W(J_W), .IDX_W(IDX_W)) u_rx_ord (
    .len(fq_q.len), .lsb_first(fq_q.lsb_first), .j(edge_q[EDGE_W-1:1]),
    .idx(rx_idx), .is_par(rx_is_par)
  );

  spi_fmt_order #(.LEN_W(LEN_W), .J_W(J_W), .IDX_W(IDX_W)) u_tx_ord (
    .len(fq_q.len), .lsb_first(fq_q.lsb_first), .j(J_W'(drv_full)),
    .idx(tx_idx), .is_par(tx_is_par)
  );

  assign tx_par   = (^txw_q) ^ fq_q.par_odd;
  assign drv_bit  = tx_is_par ? tx_par : txw_q[tx_idx];
  assign perr_now = fq_q.par_en && (rxp_q != ((^rxw_q) ^ fq_q.par_odd));
  assign gap_last = {fq_q.gap, 1'b0} - GCNT_W'(1);

  // acceptance-time view of the selected profile
  always_comb begin
    for (int i = 0; i < DATA_W; i++) tx_mask[i] = (i < int'(sel_fmt.len));
  end
  assign sel_top   = sel_fmt.len - LEN_W'(1);
  assign first_bit = sel_fmt.lsb_first ? tx_data[0] : tx_data[IDX_W'(sel_top)];

  always_comb begin
    st_d   = st_q;
    edge_d = edge_q;
    gcnt_d = gcnt_q;
    fq_d   = fq_q;
    txw_d  = txw_q;
    rxw_d  = rxw_q;
    rxp_d  = rxp_q;
    mosi_d = mosi_q;
    sclk_d = sclk_q;
    csn_d  = csn_q;
    rxv_d  = 1'b0;
    rxd_d  = rxd_q;
    perr_d = perr_q & ~par_err_clr;
    irq_d  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (tx_valid) begin
          st_d   = ST_SHIFT;
          edge_d = '0;
          fq_d   = sel_fmt;
          txw_d  = tx_data & tx_mask;
          rxw_d  = '0;
          rxp_d  = 1'b0;
          csn_d  = 1'b0;
          sclk_d = sel_fmt.cpol;
          if (!sel_fmt.cpha) mosi_d = first_bit;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          sclk_d = ~sclk_q;
          if (samp_edge) begin
            if (rx_is_par) rxp_d = miso;
            else           rxw_d[rx_idx] = miso;
          end else if (drv_valid) begin
            mosi_d = drv_bit;
          end
          if (last_edge) st_d = ST_TAIL;
          else           edge_d = edge_q + EDGE_W'(1);
        end
      end
      ST_TAIL: begin
        if (tick) begin
          csn_d  = 1'b1;
          rxv_d  = 1'b1;
          rxd_d  = rxw_q;
          gcnt_d = '0;
          if (perr_now) begin
            perr_d = 1'b1;
            irq_d  = irq_en;
          end
          st_d = (fq_q.gap == '0) ? ST_IDLE : ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gcnt_q == gap_last) st_d = ST_IDLE;
          else                    gcnt_d = gcnt_q + GCNT_W'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      gcnt_q <= '0;
      fq_q   <= '0;
      txw_q  <= '0;
      rxw_q  <= '0;
      rxp_q  <= 1'b0;
      mosi_q <= 1'b0;
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      rxv_q  <= 1'b0;
      rxd_q  <= '0;
      perr_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      gcnt_q <= gcnt_d;
      fq_q   <= fq_d;
      txw_q  <= txw_d;
      rxw_q  <= rxw_d;
      rxp_q  <= rxp_d;
      mosi_q <= mosi_d;
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      rxv_q  <= rxv_d;
      rxd_q  <= rxd_d;
      perr_q <= perr_d;
      irq_q  <= irq_d;
    end
  end

  assign tx_ready = (st_q == ST_IDLE);
  assign rx_valid = rxv_q;
  assign rx_data  = rxd_q;
  assign par_err  = perr_q;
  assign irq      = irq_q;
  assign sclk     = sclk_q;
  assign mosi     = mosi_q;
  assign cs_n     = csn_q;
endmodule

// File: rtl/spi_fmt_master_chk.sv
module spi_fmt_master_chk #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              par_err,
  input logic              par_err_clr,
  input logic              irq,
  input logic [LEN_W-1:0]  word_len
);
  AST_READY_ONLY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> cs_n); // R9

  AST_SCLK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> $stable(sclk)); // R2

  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data >> word_len) == '0)); // R6

  AST_RX_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R10

  AST_RX_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(cs_n)); // R10

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (par_err && rx_valid)); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !par_err_clr) |=> par_err); // R8
endmodule

bind spi_fmt_master spi_fmt_master_chk #(.DATA_W(DATA_W), .LEN_W(spi_fmt_pkg::LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .par_err(par_err),
  .par_err_clr(par_err_clr), .irq(irq), .word_len(fq_q.len)
);

// File: tb/spi_fmt_master_tb_top.sv
module spi_fmt_master_tb_top;
  logic        clk, rst_n;
  logic        cfg_we, cfg_cpol, cfg_cpha, cfg_lsb_first, cfg_par_en, cfg_par_odd;
  logic [1:0]  cfg_idx, tx_fmt;
  logic [4:0]  cfg_len;
  logic [7:0]  cfg_presc, cfg_gap;
  logic        tx_valid, tx_ready, rx_valid, par_err, par_err_clr, irq_en, irq;
  logic [15:0] tx_data, rx_data;
  logic        sclk, mosi, miso, cs_n;

  spi_fmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_len(cfg_len),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_presc(cfg_presc),
    .cfg_gap(cfg_gap), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_fmt(tx_fmt),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .par_err(par_err),
    .par_err_clr(par_err_clr), .irq_en(irq_en), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench copy of the profile table
  int p_len[4], p_presc[4], p_gap[4];
  bit p_cpol[4], p_cpha[4], p_lsb[4], p_pen[4], p_podd[4];
  bit exp_perr = 0;
  int last_rise = 0, last_gap = 0, last_presc = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] len_mask(int len);
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) if (i < len) m[i] = 1'b1;
    return m;
  endfunction

  // wire order of a word: bit j of the result is the j-th bit on the line
  function automatic logic [16:0] wire_seq(logic [15:0] w, int len, bit lsb, bit pen, bit podd);
    logic [16:0] s = '0;
    logic [15:0] mw = w & len_mask(len);
    for (int j = 0; j < len; j++) s[j] = lsb ? mw[j] : mw[len - 1 - j];
    if (pen) s[len] = (^mw) ^ podd;
    return s;
  endfunction

  task automatic write_fmt(int idx, int len, bit cpol, bit cpha, bit lsb,
                           bit pen, bit podd, int presc, int gap);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_len = 5'(len); cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_lsb_first = lsb; cfg_par_en = pen; cfg_par_odd = podd;
    cfg_presc = 8'(presc); cfg_gap = 8'(gap);
    p_len[idx] = (len < 2) ? 2 : ((len > 16) ? 16 : len);
    p_cpol[idx] = cpol; p_cpha[idx] = cpha; p_lsb[idx] = lsb;
    p_pen[idx] = pen; p_podd[idx] = podd; p_presc[idx] = presc; p_gap[idx] = gap;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rand_fmt(int idx);
    int l = 2 + int'($urandom_range(0, 14));
    write_fmt(idx, l, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              1'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
  endtask

  // one frame; b2b=1 when this word was already waiting as the previous frame ended
  task automatic do_word(int f, logic [15:0] d, logic [15:0] m, bit bad, bit b2b, bit clr_hold);
    int len = p_len[f];
    int n = len + (p_pen[f] ? 1 : 0);
    logic [16:0] mo_exp = wire_seq(d, len, p_lsb[f], p_pen[f], p_podd[f]);
    logic [16:0] mi_seq = wire_seq(m, len, p_lsb[f], p_pen[f], p_podd[f]);
    logic [16:0] mo_got = '0;
    int t_fall, t_first = -1, t_last = 0, edges = 0, sj = 0, rj = 0, irq_cnt = 0;
    bit prev, err;
    if (p_pen[f] && bad) mi_seq[len] = ~mi_seq[len];
    err = p_pen[f] && bad;
    tx_fmt = 2'(f); tx_data = d; tx_valid = 1;
    par_err_clr = clr_hold;
    do @(negedge clk); while (cs_n === 1'b1 && !done);
    t_fall = cyc;
    tx_valid = 0;
    chk("R2 idle sclk level at select", 32'(sclk), 32'(p_cpol[f]));
    if (b2b) chk("R9 deselect gap", 32'(t_fall - last_rise),
                 32'(2 * last_gap * (last_presc + 1) + 1));
    if (!p_cpha[f]) begin miso = mi_seq[0]; rj = 1; end
    prev = sclk;
    forever begin
      @(negedge clk);
      if (irq) irq_cnt++;
      if (cs_n === 1'b1 || done) break;
      if (sclk !== prev) begin
        bit lead = (prev == p_cpol[f]);
        bit samp = p_cpha[f] ? !lead : lead;
        edges++;
        if (t_first < 0) t_first = cyc;
        t_last = cyc;
        if (samp) begin mo_got[sj] = mosi; sj++; end
        else begin if (rj < n) miso = mi_seq[rj]; rj++; end
        prev = sclk;
      end
    end
    chk("R4 sclk edge count", 32'(edges), 32'(2 * n));
    chk("R2 select-to-first-edge", 32'(t_first - t_fall), 32'(p_presc[f] + 1));
    chk("R2 last-edge-to-deselect", 32'(cyc - t_last), 32'(p_presc[f] + 1));
    chk("R5 R7 R3 mosi wire sequence", 32'(mo_got), 32'(mo_exp & 17'((1 << n) - 1)));
    chk("R10 rx_valid at deselect", 32'(rx_valid), 32'd1);
    chk("R6 rx_data right-aligned", 32'(rx_data), 32'(m & len_mask(len)));
    if (clr_hold) exp_perr = err; else exp_perr = exp_perr | err;
    chk("R8 parity error flag", 32'(par_err), 32'(exp_perr));
    chk("R8 irq pulse", 32'(irq_cnt), 32'((err && irq_en) ? 1 : 0));
    last_rise = cyc; last_gap = p_gap[f]; last_presc = p_presc[f];
    par_err_clr = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_len = 0; cfg_cpol = 0; cfg_cpha = 0;
    cfg_lsb_first = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_presc = 0; cfg_gap = 0;
    tx_valid = 0; tx_fmt = 0; tx_data = 0; par_err_clr = 0; irq_en = 0; miso = 0;
    for (int i = 0; i < 4; i++) begin
      p_len[i] = 16; p_cpol[i] = 0; p_cpha[i] = 0; p_lsb[i] = 0;
      p_pen[i] = 0; p_podd[i] = 0; p_presc[i] = 0; p_gap[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset tx_ready", 32'(tx_ready), 32'd1);
    chk("R2 reset cs_n", 32'(cs_n), 32'd1);
    chk("R2 reset sclk", 32'(sclk), 32'd0);
    chk("R10 reset rx_valid", 32'(rx_valid), 32'd0);
    chk("R8 reset par_err", 32'(par_err), 32'd0);

    // R1 reset profile: 16 bits, MSB first
    do_word(3, 16'hA5C3, 16'h3C5A, 0, 0, 0);
    // R5 12-bit MSB-first, upper bits of tx_data must not matter
    write_fmt(0, 12, 0, 0, 0, 0, 0, 1, 2);
    do_word(0, 16'hFEC9, 16'hFFFF, 0, 0, 0);
    do_word(0, 16'h0EC9, 16'h1234, 0, 1, 0);
    // R6 10-bit receive of 0x0A2, LSB first, phase 1, odd parity
    write_fmt(1, 10, 1, 1, 1, 1, 1, 0, 0);
    do_word(1, 16'h0155, 16'hFCA2, 0, 0, 0);
    // R4 length limits
    write_fmt(2, 0, 0, 1, 0, 0, 0, 0, 1);
    do_word(2, 16'hFFFE, 16'h0003, 0, 0, 0);
    write_fmt(2, 31, 1, 0, 1, 1, 0, 2, 0);
    do_word(2, 16'h8001, 16'h7FFE, 0, 0, 0);
    // R8 parity error with interrupt, then set beating a held clear
    irq_en = 1;
    do_word(1, 16'h0321, 16'h0123, 1, 1, 0);
    do_word(1, 16'h0001, 16'h0002, 1, 1, 1);
    @(negedge clk); par_err_clr = 1; @(negedge clk); par_err_clr = 0;
    exp_perr = 0;
    chk("R8 par_err cleared", 32'(par_err), 32'd0);
    // R1 in-flight word keeps its profile while the slot is rewritten
    write_fmt(0, 8, 0, 0, 0, 0, 0, 1, 0);
    fork
      do_word(0, 16'h00C6, 16'h0039, 0, 0, 0);
      begin repeat (4) @(negedge clk); cfg_we = 1; cfg_idx = 0; cfg_len = 5'd3;
            @(negedge clk); cfg_we = 0; end
    join
    p_len[0] = 3;
    do_word(0, 16'h0005, 16'h0002, 0, 1, 0);

    // random bursts
    for (int b = 0; b < 8; b++) begin
      for (int i = 0; i < 4; i++) rand_fmt(i);
      irq_en = 1'($urandom);
      for (int k = 0; k < 20; k++)
        do_word(int'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
                ($urandom_range(0, 3) == 0), (k != 0), 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule